// File: doc/BRIEF.md
# Horizontal Line Timing Generator (down-counting)

This block produces the horizontal timing of one raster line for a panel driven from a pixel clock. A line counter is loaded with a programmed total and counts down by one on every pixel clock until it reaches zero. It then reloads. Four windows hang off that count: horizontal sync, blanking, the active-video window and an enable that gates the panel shift clock. Each window is set by a pair of counter values. It turns on when the count equals its start value and turns off when the count equals its stop value.

Software programs the block through a plain write port. Every write lands in a pending copy. All pending values move into the live set together on the reload cycle, so a line never runs on a mix of old and new settings. A pulse at count zero marks the end of each line and can step a vertical counter.

Top module: `hline_timer`

## Requirements
- R1: The line counter is loaded with the live total value when it is zero and otherwise decrements by one per clock, so a line lasts total+1 clocks.
- R2: `lineEnd` is high exactly while the line counter equals zero.
- R3: `hsync` is a registered window that turns on one clock after the count equals the sync start value and turns off one clock after the count equals the sync stop value, then holds.
- R4: `blank` follows the same start/stop rule using the blank pair.
- R5: `activeVideo` follows the same start/stop rule using the active pair and has no polarity control.
- R6: `shiftClkEn` follows the same start/stop rule using the shift-enable pair, independent of the counter, which keeps decrementing whatever its value.
- R7: Control bit 0 inverts `hsync` and control bit 1 inverts `blank`.
- R8: A window whose start equals its stop is never asserted, so the output sits at its inactive level.
- R9: Writes go to pending registers. The live total, pairs and control bits change only on the clock where the counter is zero. A write made on that same clock waits for the following reload.
- R10: After reset the counter, all pending and live registers and all windows are zero, so `lineEnd` is high and the other outputs are low.
- R11: Register map by `wrAddr`: 0 total (bits [10:0]); 1 sync, 2 blank, 3 active, 4 shift-enable pairs with start in bits [26:16] and stop in bits [10:0]; 5 control (bit 0 sync invert, bit 1 blank invert).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | 3 | Register select |
| wrData | input | 32 | Write data |
| hsync | output | 1 | Horizontal sync, polarity selectable |
| blank | output | 1 | Blanking, polarity selectable |
| activeVideo | output | 1 | Active-video window |
| shiftClkEn | output | 1 | Enable that gates the panel shift clock |
| lineEnd | output | 1 | End-of-line pulse for a vertical counter |

## Verification
Two events can land on the same clock: a register write and the reload at count zero. The write must then update only the pending copy, and the live set takes the old pending values. The bench forces this collision by waiting until its model shows a zero count and then issuing the write. It also lets random writes fall anywhere within lines of random length. Each output is compared on every clock against a model that applies the reload before the write, so a design that lets the write through early shows a wrong window edge on the next line.

// File: rtl/hline_pkg.sv
package hline_pkg;
  localparam int NUM_WIN   = 4;
  localparam int NUM_POL   = 2;
  localparam int START_LSB = 16;
  localparam int ADDR_W    = 3;
  localparam int DATA_W    = 32;

  typedef enum logic [ADDR_W-1:0] {
    REG_TOTAL  = 3'd0,
    REG_SYNC   = 3'd1,
    REG_BLANK  = 3'd2,
    REG_ACTIVE = 3'd3,
    REG_SHIFT  = 3'd4,
    REG_CTRL   = 3'd5
  } regAddr_t;

  typedef struct packed {
    logic reload;
    logic lineEnd;
  } lineStrobe_t;
endpackage

// File: rtl/hline_ctrl.sv
module hline_ctrl
  import hline_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] loadVal,
  output logic [CNT_W-1:0] count,
  output lineStrobe_t      strobe
);
  logic atZero;

  assign atZero = (count == '0);

  always_ff @(posedge clk) begin
    if (rst)         count <= '0;
    else if (atZero) count <= loadVal;
    else             count <= count - CNT_W'(1);
  end

  always_comb begin
    strobe.reload  = atZero;
    strobe.lineEnd = atZero;
  end
endmodule

// File: rtl/hline_win.sv
module hline_win #(
  parameter int CNT_W = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [CNT_W-1:0] count,
  input  logic [CNT_W-1:0] startVal,
  input  logic [CNT_W-1:0] stopVal,
  input  logic             invert,
  output logic             winOut
);
  logic winState;
  logic nextWin;

  always_comb begin
    if (startVal == stopVal)    nextWin = 1'b0;
    else if (count == startVal) nextWin = 1'b1;
    else if (count == stopVal)  nextWin = 1'b0;
    else                        nextWin = winState;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      winState <= 1'b0;
      winOut   <= 1'b0;
    end else begin
      winState <= nextWin;
      winOut   <= nextWin ^ invert;
    end
  end
endmodule

// File: rtl/hline_dp.sv
module hline_dp
  import hline_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wrEn,
  input  logic [ADDR_W-1:0]  wrAddr,
  input  logic [DATA_W-1:0]  wrData,
  input  lineStrobe_t        strobe,
  input  logic [CNT_W-1:0]   count,
  output logic [CNT_W-1:0]   pendTotal,
  output logic [NUM_WIN-1:0] winBus
);
  logic [NUM_POL-1:0] pendPol;
  logic [NUM_POL-1:0] livePol;
  logic               unusedWr;

  assign unusedWr = ^wrData;

  always_ff @(posedge clk) begin
    if (rst) begin
      pendTotal <= '0;
      pendPol   <= '0;
      livePol   <= '0;
    end else begin
      if (strobe.reload) livePol <= pendPol;
      if (wrEn && wrAddr == REG_TOTAL) pendTotal <= wrData[CNT_W-1:0];
      if (wrEn && wrAddr == REG_CTRL)  pendPol   <= wrData[NUM_POL-1:0];
    end
  end

  for (genvar i = 0; i < NUM_WIN; i++) begin : gWin
    localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(int'(REG_SYNC) + i);
    logic [CNT_W-1:0] pendStart, pendStop, liveStart, liveStop;
    logic             inv;

    always_ff @(posedge clk) begin
      if (rst) begin
        pendStart <= '0;
        pendStop  <= '0;
        liveStart <= '0;
        liveStop  <= '0;
      end else begin
        if (strobe.reload) begin
          liveStart <= pendStart;
          liveStop  <= pendStop;
        end
        if (wrEn && wrAddr == MY_ADDR) begin
          pendStart <= wrData[START_LSB +: CNT_W];
          pendStop  <= wrData[CNT_W-1:0];
        end
      end
    end

    if (i < NUM_POL) begin : gPol
      assign inv = livePol[i];
    end else begin : gNoPol
      assign inv = 1'b0;
    end

    hline_win #(.CNT_W(CNT_W)) uWin (
      .clk      (clk),
      .rst      (rst),
      .count    (count),
      .startVal (liveStart),
      .stopVal  (liveStop),
      .invert   (inv),
      .winOut   (winBus[i])
    );
  end
endmodule

// File: rtl/hline_timer.sv
module hline_timer
  import hline_pkg::*;
#(
  parameter int CNT_W = 11
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        wrEn,
  input  logic [2:0]  wrAddr,
  input  logic [31:0] wrData,
  output logic        hsync,
  output logic        blank,
  output logic        activeVideo,
  output logic        shiftClkEn,
  output logic        lineEnd
);
  logic [CNT_W-1:0]   count;
  logic [CNT_W-1:0]   pendTotal;
  lineStrobe_t        strobe;
  logic [NUM_WIN-1:0] winBus;

  hline_ctrl #(.CNT_W(CNT_W)) uCtrl (
    .clk     (clk),
    .rst     (rst),
    .loadVal (pendTotal),
    .count   (count),
    .strobe  (strobe)
  );

  hline_dp #(.CNT_W(CNT_W)) uDp (
    .clk       (clk),
    .rst       (rst),
    .wrEn      (wrEn),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .count     (count),
    .pendTotal (pendTotal),
    .winBus    (winBus)
  );

  assign hsync       = winBus[0];
  assign blank       = winBus[1];
  assign activeVideo = winBus[2];
  assign shiftClkEn  = winBus[3];
  assign lineEnd     = strobe.lineEnd;
endmodule

// File: rtl/hline_timer_chk.sv
module hline_timer_chk #(
  parameter int CNT_W = 11
) (
  input logic             clk,
  input logic             rst,
  input logic             wrEn,
  input logic [2:0]       wrAddr,
  input logic [31:0]      wrData,
  input logic [CNT_W-1:0] count,
  input logic [CNT_W-1:0] pendTotal,
  input logic             lineEnd
);
  // R1
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    (count != '0) |=> (count == $past(count) - CNT_W'(1)));

  // R1
  count_reload_chk: assert property (@(posedge clk) disable iff (rst)
    (count == '0) |=> (count == $past(pendTotal)));

  // R2
  line_end_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    (lineEnd && pendTotal != '0) |=> !lineEnd);

  // R11
  total_write_chk: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == 3'd0) |=> (pendTotal == $past(wrData[CNT_W-1:0])));
endmodule

bind hline_timer hline_timer_chk #(.CNT_W(CNT_W)) uChk (
  .clk       (clk),
  .rst       (rst),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .count     (count),
  .pendTotal (pendTotal),
  .lineEnd   (lineEnd)
);

// File: tb/tb_hline_timer.sv
`timescale 1ns/1ps
module tb_hline_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [2:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        hsync, blank, activeVideo, shiftClkEn, lineEnd;

  always #4 clk = ~clk;

  hline_timer dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .hsync(hsync), .blank(blank), .activeVideo(activeVideo),
    .shiftClkEn(shiftClkEn), .lineEnd(lineEnd)
  );

  int errors = 0;
  int checks = 0;
  bit done = 0;
  string phase = "R10";

  // reference model state
  int mCnt, mPT, mPP, mLP;
  int mPS[4], mPE[4], mLS[4], mLE[4];
  bit mW[4];
  bit eHs, eBl, eAc, eSh;

  task automatic check(string name, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL [%s] %s actual=%0d expected=%0d t=%0t", phase, name, got, exp, $time);
    end
  endtask

  task automatic modelStep();
    if (rst) begin
      mCnt = 0; mPT = 0; mPP = 0; mLP = 0;
      for (int i = 0; i < 4; i++) begin
        mPS[i] = 0; mPE[i] = 0; mLS[i] = 0; mLE[i] = 0; mW[i] = 0;
      end
      eHs = 0; eBl = 0; eAc = 0; eSh = 0;
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (mLS[i] == mLE[i]) mW[i] = 0;
        else if (mCnt == mLS[i]) mW[i] = 1;
        else if (mCnt == mLE[i]) mW[i] = 0;
      end
      eHs = mW[0] ^ mLP[0];
      eBl = mW[1] ^ mLP[1];
      eAc = mW[2];
      eSh = mW[3];
      if (mCnt == 0) begin
        mLP = mPP;
        for (int i = 0; i < 4; i++) begin mLS[i] = mPS[i]; mLE[i] = mPE[i]; end
        mCnt = mPT;
      end else begin
        mCnt = mCnt - 1;
      end
      if (wrEn) begin
        case (wrAddr)
          3'd0: mPT = int'(wrData & 32'h7FF);
          3'd1, 3'd2, 3'd3, 3'd4: begin
            mPS[wrAddr-1] = int'((wrData >> 16) & 32'h7FF);
            mPE[wrAddr-1] = int'(wrData & 32'h7FF);
          end
          3'd5: mPP = int'(wrData & 32'h3);
          default: ;
        endcase
      end
    end
  endtask

  task automatic tick();
    @(posedge clk);
    modelStep();
    @(negedge clk);
    check("hsync R3/R7", hsync, eHs);
    check("blank R4/R7", blank, eBl);
    check("activeVideo R5", activeVideo, eAc);
    check("shiftClkEn R6", shiftClkEn, eSh);
    check("lineEnd R2", lineEnd, (mCnt == 0));
  endtask

  task automatic wr(int addr, int data);
    wrEn = 1; wrAddr = 3'(addr); wrData = 32'(data);
    tick();
    wrEn = 0;
  endtask

  function automatic int pair(int s, int e);
    return ((s & 2047) << 16) | (e & 2047);
  endfunction

  task automatic run(int n);
    for (int k = 0; k < n; k++) tick();
  endtask

  initial begin
    int seed = 32'h5EED1234;
    int len;
    void'($urandom(seed));
    // R10: reset state
    run(3);
    check("reset lineEnd R10", lineEnd, 1);
    check("reset hsync R10", hsync, 0);
    rst = 0;
    run(2);

    // R11: program a full line through the register map
    phase = "R11";
    wr(0, 19);
    wr(1, pair(18, 15));
    wr(2, pair(5, 19));
    wr(3, pair(15, 5));
    wr(4, pair(16, 4));
    wr(5, 0);
    run(60);

    // R1: line length equals total+1
    phase = "R1";
    while (!lineEnd) tick();
    len = 0;
    tick(); len++;
    while (!lineEnd) begin tick(); len++; end
    check("line length R1", len, 20);

    // R7: polarity inversion
    phase = "R7";
    wr(5, 3);
    run(45);

    // R8: start equals stop keeps the window idle
    phase = "R8";
    wr(1, pair(7, 7));
    wr(3, pair(12, 12));
    run(45);
    check("idle sync level R8", hsync, 1);
    check("idle active level R8", activeVideo, 0);

    // R9: mid-line write, then a write landing on the reload clock
    phase = "R9";
    wr(1, pair(18, 15));
    run(25);
    while (mCnt != 10) tick();
    wr(0, 29);
    wr(1, pair(25, 20));
    run(50);
    while (mCnt != 0) tick();
    wr(0, 13);
    wr(3, pair(11, 2));
    run(70);

    // random lines and writes at random times
    phase = "RND";
    for (int it = 0; it < 300; it++) begin
      int t = 3 + int'($urandom_range(60));
      int a = int'($urandom_range(5));
      int s = int'($urandom_range(t));
      int e = ($urandom_range(7) == 0) ? s : int'($urandom_range(t));
      case (a)
        0: wr(0, t);
        5: wr(5, int'($urandom_range(3)));
        default: wr(a, pair(s, e) | int'($urandom & 32'hF800_F800));
      endcase
      run(int'($urandom_range(40)));
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL [watchdog] run did not finish actual=0 expected=1");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule